// File: doc/BRIEF.md
# Edge-Interval Clock Multiplier

This block turns a slow external edge stream into a fast, evenly spaced pulse train. It counts system clocks between successive rising edges of an asynchronous input, divides that count by 32, 64, 128 or 256, and uses the quotient as the period of a reloading down-counter. Each time the down-counter wraps it emits a one-cycle pulse, so the pulse rate follows the input edge rate multiplied by the chosen ratio.

A typical use is to derive a fine angle or phase tick from a coarse tooth or index signal. Each new edge retunes the pulse period to the most recent measured interval. An enable input freezes the pulse generator without losing its phase, and measurement carries on while it is frozen.

Top module: `edge_clk_mult`

## Requirements
- R1: `ext_in` passes through a two-flop synchronizer and a rising-edge detector. A rising edge first sampled high at clock edge k causes a capture at clock edge k+2, and its results show on the outputs after that edge. An input that stays high produces exactly one capture.
- R2: `interval_q` holds the number of clock cycles between the two most recent captures. The count saturates at 16'hFFFF when no edge arrives.
- R3: At each capture, the measured interval is shifted right by 5, 6, 7 or 8 bits for `ratio_sel` values 2'b00, 2'b01, 2'b10 and 2'b11. `ratio_sel` is sampled only at the capture edge.
- R4: A scaled value of 0 is replaced by 1. This gives a pulse on every enabled cycle.
- R5: On a capture edge, `reload_q` and the down-counter both take the scaled value.
- R6: While enabled, a pulse appears every R enabled cycles after a capture, where R is `reload_q`. Each pulse is one cycle wide when R > 1.
- R7: A capture takes priority over a pending wrap. No pulse is produced on the capture edge, and counting restarts from the new value.
- R8: While `enable` is low, the down-counter holds and `mult_pulse` stays low. Captures and reload updates continue. Counting resumes from the held value.
- R9: After a synchronous reset, all outputs are zero, and no pulse appears until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 1 | Asynchronous external edge input |
| ratio_sel | input | 2 | Multiplication ratio select (32/64/128/256) |
| enable | input | 1 | Pulse generator run enable |
| mult_pulse | output | 1 | Multiplied single-cycle pulse |
| interval_q | output | 16 | Last captured edge-to-edge interval |
| reload_q | output | 16 | Current reload value |

## Verification
The bench targets intervals short enough that the shift gives zero. A design that forgot the clamp to 1 would stall with no pulses. It also checks wraps that coincide with a capture: a design without capture priority would emit an extra pulse or restart from the stale value. A long silent stretch checks saturation; a wrapping interval counter would report a tiny interval and a far too fast pulse rate. Random toggling of enable and ratio mid-interval catches a counter that drifts while frozen and a ratio that is sampled outside the capture edge.

// File: rtl/ecm_pkg.sv
package ecm_pkg;
  typedef enum logic [1:0] {
    RATIO_X32  = 2'b00,
    RATIO_X64  = 2'b01,
    RATIO_X128 = 2'b10,
    RATIO_X256 = 2'b11
  } ratio_e;

  localparam int BASE_SHIFT = 5;

  function automatic logic [4:0] shift_of(ratio_e r);
    return 5'(BASE_SHIFT) + {3'b000, r};
  endfunction
endpackage

// File: rtl/ecm_edge_sync.sv
module ecm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_stb
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[gi] <= 1'b0;
          else     sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise_stb = sync_q[STAGES-1] & ~prev_q;

  // R1: a strobe never lasts two cycles
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rise_stb |=> !rise_stb);
endmodule

// File: rtl/ecm_interval_meter.sv
module ecm_interval_meter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  output logic [W-1:0] live_cnt,
  output logic [W-1:0] interval_q
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      interval_q <= '0;
    end else if (stb) begin
      interval_q <= cnt_q;
      cnt_q      <= W'(1);
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign live_cnt = cnt_q;

  // R2: a saturated count stays saturated until the next capture
  a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !stb) |=> cnt_q == CNT_MAX);

  // R2: the reported interval only moves on a capture
  a_r2_interval_stable: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(interval_q));
endmodule

// File: rtl/ecm_reload_gen.sv
module ecm_reload_gen
  import ecm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         load,
  input  ratio_e       ratio,
  input  logic [W-1:0] meas,
  output logic         pulse_q,
  output logic [W-1:0] reload_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] shifted;
  logic [W-1:0] scaled;
  logic [W-1:0] dcnt_q;

  always_comb begin
    shifted = meas >> shift_of(ratio);
    scaled  = (shifted == '0) ? ONE : shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      dcnt_q   <= '0;
      pulse_q  <= 1'b0;
    end else if (load) begin
      reload_q <= scaled;
      dcnt_q   <= scaled;
      pulse_q  <= 1'b0;
    end else if (enable && dcnt_q != '0) begin
      if (dcnt_q == ONE) begin
        dcnt_q  <= reload_q;
        pulse_q <= 1'b1;
      end else begin
        dcnt_q  <= dcnt_q - ONE;
        pulse_q <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end

  // R4: a freshly loaded reload value is never zero
  a_r4_nonzero_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> reload_q != '0);

  // R6: a pulse coincides with the counter restarting from the buffer
  a_r6_pulse_reloads: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> dcnt_q == reload_q);

  // R7: the capture edge never yields a pulse
  a_r7_capture_priority: assert property (@(posedge clk) disable iff (rst)
    load |=> !pulse_q);

  // R8: frozen counter holds and stays silent
  a_r8_hold_count: assert property (@(posedge clk) disable iff (rst)
    (!enable && !load) |=> $stable(dcnt_q));
  a_r8_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pulse_q);
endmodule

// File: rtl/edge_clk_mult.sv
module edge_clk_mult
  import ecm_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_in,
  input  logic [1:0]   ratio_sel,
  input  logic         enable,
  output logic         mult_pulse,
  output logic [W-1:0] interval_q,
  output logic [W-1:0] reload_q
);
  logic         rise_stb;
  logic [W-1:0] live_cnt;

  ecm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .din      (ext_in),
    .rise_stb (rise_stb)
  );

  ecm_interval_meter #(.W(W)) u_meter (
    .clk        (clk),
    .rst        (rst),
    .stb        (rise_stb),
    .live_cnt   (live_cnt),
    .interval_q (interval_q)
  );

  ecm_reload_gen #(.W(W)) u_reload (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .load     (rise_stb),
    .ratio    (ratio_e'(ratio_sel)),
    .meas     (live_cnt),
    .pulse_q  (mult_pulse),
    .reload_q (reload_q)
  );

  // R9: nothing is emitted in the cycle after reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mult_pulse && reload_q == '0));
endmodule

// File: tb/edge_clk_mult_tb.sv
module edge_clk_mult_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_in = 1'b0;
  logic [1:0]  ratio_sel = 2'b00;
  logic        enable = 1'b0;
  logic        mult_pulse;
  logic [15:0] interval_q;
  logic [15:0] reload_q;

  always #10 clk = ~clk;

  edge_clk_mult u_dut (
    .clk(clk), .rst(rst), .ext_in(ext_in), .ratio_sel(ratio_sel),
    .enable(enable), .mult_pulse(mult_pulse),
    .interval_q(interval_q), .reload_q(reload_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference state
  logic        e1, e2, e3;
  int          m_cnt, m_int, m_rel, m_ph;
  logic        m_loaded, m_pulse;

  function automatic int scale_of(int iv, logic [1:0] r);
    int v;
    v = iv >> (5 + int'(r));
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // one cycle: drive, let a posedge pass, update reference, compare
  task automatic step(logic x, logic en, logic [1:0] r, logic rs);
    logic stb;
    string ptag, rtag;
    ext_in = x; enable = en; ratio_sel = r; rst = rs;
    @(negedge clk);
    if (rs) begin
      e1 = 0; e2 = 0; e3 = 0; m_cnt = 0; m_int = 0; m_rel = 0;
      m_ph = 0; m_loaded = 0; m_pulse = 0;
      return;
    end
    stb = e2 && !e3;
    e3 = e2; e2 = e1; e1 = x;
    if (stb) begin
      m_int = m_cnt;
      m_rel = scale_of(m_cnt, r);
      m_cnt = 1; m_ph = 0; m_loaded = 1; m_pulse = 0;
      ptag = "R7";
      rtag = (m_rel == 1) ? "R4" : "R1";
    end else begin
      if (m_cnt != 16'hFFFF) m_cnt++;
      if (en && m_loaded) begin
        m_ph++;
        m_pulse = (m_ph % m_rel) == 0;
        ptag = "R6";
      end else begin
        m_pulse = 0;
        ptag = m_loaded ? "R8" : "R9";
      end
      rtag = "R5";
    end
    chk(ptag, int'(mult_pulse), int'(m_pulse));
    chk((m_int == 16'hFFFF) ? "R2 saturated" : "R2", int'(interval_q), m_int);
    chk(rtag == "R1" ? "R3" : rtag, int'(reload_q), m_rel);
  endtask

  task automatic wave(int period, int edges, logic [1:0] r, bit rnd_en, bit rnd_r);
    for (int e = 0; e < edges; e++) begin
      for (int c = 0; c < period; c++) begin
        logic en;
        logic [1:0] rr;
        en = rnd_en ? (($urandom % 6) != 0) : 1'b1;
        rr = (rnd_r && ($urandom % 50) == 0) ? 2'($urandom) : r;
        step(c < (period / 2), en, rr, 1'b0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 2'b00, 1'b1);
    // R9: reset state
    chk("R9", int'(mult_pulse), 0);
    chk("R9", int'(interval_q), 0);
    chk("R9", int'(reload_q), 0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 2'b00, 1'b0);
    chk("R9 no pulse before capture", int'(mult_pulse), 0);

    // directed: exact multiples for each ratio (R3, R6, R7)
    wave(2048, 4, 2'b00, 0, 0);
    wave(2048, 3, 2'b01, 0, 0);
    wave(2048, 3, 2'b10, 0, 0);
    wave(2048, 3, 2'b11, 0, 0);
    // R4: tiny intervals force reload of 1
    wave(10, 6, 2'b00, 0, 0);
    wave(40, 4, 2'b11, 0, 0);
    // R1: input held high gives one capture
    for (int i = 0; i < 3000; i++) step(1'b1, 1'b1, 2'b00, 1'b0);
    // R2: long silence saturates the interval
    for (int i = 0; i < 70000; i++) step(1'b0, 1'b1, 2'b01, 1'b0);
    wave(300, 2, 2'b00, 0, 0);
    // R8: enable dropped for a stretch
    wave(1000, 2, 2'b00, 0, 0);
    for (int i = 0; i < 200; i++) step(1'b0, 1'b0, 2'b00, 1'b0);
    wave(1000, 2, 2'b01, 1, 0);

    // constrained random
    for (int s = 0; s < 30; s++) begin
      int p;
      p = 12 + int'($urandom % 1200);
      wave(p, 2 + int'($urandom % 3), 2'($urandom), ($urandom % 2) == 1,
           ($urandom % 3) == 0);
    end
    summary();
  end
endmodule